// File: doc/BRIEF.md
# H-Bridge Gate Control Sequencer

This block produces the four gate commands of a full bridge: an upper and a lower switch on leg A and on leg B. Its inputs are a direction bit from an external comparator, a high-side enable, a disable pin and an 8-bit code that samples the bias supply. A three-state sequencer decides whether the bridge may conduct. In `ST_LOCK` all gates are off. In `ST_REFRESH`, after release, both lower switches are on so that the high-side bootstrap capacitors can charge. In `ST_RUN` the gates follow the inputs.

There are four transitions. `ST_LOCK` goes to `ST_REFRESH` when the block is neither disabled nor in undervoltage. `ST_REFRESH` goes to `ST_RUN` once the refresh count expires. `ST_REFRESH` goes back to `ST_LOCK` on a disable or an undervoltage, and so does `ST_RUN`.

Each leg has its own dead-time unit. A switch is turned off as soon as its command drops. A turn-on waits a programmable number of cycles, and the count for upper switches is set separately from the count for lower switches. An undervoltage flag with hysteresis watches the supply code. The block uses one clock and an active-high synchronous reset.

Top module: `gate_seq`

## Requirements
- R1: During and after reset all four gate outputs are 0 and the sequencer is in `ST_LOCK` with the undervoltage flag set.
- R2: After any clock edge at which `dis` is sampled 1, all four outputs are 0 and stay 0 for as long as `dis` remains 1.
- R3: Undervoltage sets when `vsup` < `UV_LO` at an edge, and all outputs are 0 from the following edge on. It clears only when `vsup` > `UV_HI`. Codes from `UV_LO` to `UV_HI` inclusive leave the flag unchanged.
- R4: In `ST_RUN` with `hi_en`=1, `dir`=1 selects A-upper plus B-lower, and `dir`=0 selects A-lower plus B-upper.
- R5: With `hi_en`=0, both upper outputs are 0 after the edge that samples it. In `ST_RUN` the lower switch of the selected diagonal still follows `dir`: B-lower when `dir`=1, A-lower when `dir`=0.
- R6: When the block is released from lock, it spends `REFRESH_CYC` cycles in `ST_REFRESH`. In that phase both lower outputs turn on (after the lower dead time) and both upper outputs stay 0. Only then do the outputs follow the inputs.
- R7: A gate output falls after the first edge at which its command is no longer present.
- R8: A turn-on command first sampled at edge E raises its output after edge E+D+1. D is `up_dly` for upper switches and `lo_dly` for lower switches.
- R9: If a command is withdrawn and then presented again while its delay is still running, the count starts again from the full value.
- R10: With a delay of 0, both switches of a leg are off for at least one full cycle between one switch turning off and the other turning on.
- R11: The upper and lower outputs of the same leg are never both 1 in any cycle, under any input sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dir | input | 1 | Direction compare result (1: A-upper/B-lower diagonal) |
| hi_en | input | 1 | Enables the two upper switches |
| dis | input | 1 | Forces all gates off |
| vsup | input | SW (8) | Digitized supply voltage code |
| up_dly | input | DW (8) | Upper turn-on delay in cycles |
| lo_dly | input | DW (8) | Lower turn-on delay in cycles |
| a_hi | output | 1 | Leg A upper gate |
| a_lo | output | 1 | Leg A lower gate |
| b_hi | output | 1 | Leg B upper gate |
| b_lo | output | 1 | Leg B lower gate |

## Verification
A wrong sequencer state shows at the ports within a single cycle. Examples are staying in `ST_REFRESH` too long, or never leaving it. Both lower gates would remain high where an upper gate or a lone lower gate was expected, and the checks at the refresh boundary sample exactly on that edge. A dead-time counter that is wrong, or that is not reloaded, moves a rising gate edge by one or more cycles. Every turn-on is therefore sampled both on the cycle before the expected rise and on the cycle of the rise. A leg whose output registers disagree with their commands would show both gates high, and a per-cycle check catches that in the same cycle.

// File: rtl/gsq_pkg.sv
package gsq_pkg;
    typedef enum logic [1:0] {
        ST_LOCK    = 2'd0,
        ST_REFRESH = 2'd1,
        ST_RUN     = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_HI   = 2'd1,
        TGT_LO   = 2'd2
    } leg_tgt_t;
endpackage

// File: rtl/gsq_uvlo.sv
module gsq_uvlo #(
    parameter int SW = 8,
    parameter logic [SW-1:0] UV_LO = 8'd100,
    parameter logic [SW-1:0] UV_HI = 8'd110
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] sample,
    output logic          uv
);
    always_ff @(posedge clk) begin
        if (rst) begin
            uv <= 1'b1;
        end else if (uv && (sample > UV_HI)) begin
            uv <= 1'b0;
        end else if (!uv && (sample < UV_LO)) begin
            uv <= 1'b1;
        end
    end
endmodule

// File: rtl/gsq_leg.sv
module gsq_leg
    import gsq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_hi,
    input  logic          req_lo,
    input  logic [DW-1:0] hi_dly,
    input  logic [DW-1:0] lo_dly,
    output logic          hi_on,
    output logic          lo_on
);
    leg_tgt_t      tgt;
    leg_tgt_t      prev_tgt;
    logic [DW-1:0] cnt;
    logic          settled;

    always_comb begin
        if (req_hi)      tgt = TGT_HI;
        else if (req_lo) tgt = TGT_LO;
        else             tgt = TGT_NONE;
    end

    // request held for at least one edge and its dead time consumed
    assign settled = (tgt == prev_tgt) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_tgt <= TGT_NONE;
            cnt      <= '0;
            hi_on    <= 1'b0;
            lo_on    <= 1'b0;
        end else begin
            prev_tgt <= tgt;
            if (tgt != prev_tgt) begin
                unique case (tgt)
                    TGT_HI:  cnt <= hi_dly;
                    TGT_LO:  cnt <= lo_dly;
                    default: cnt <= '0;
                endcase
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
            hi_on <= (tgt == TGT_HI) && (hi_on || (settled && !lo_on));
            lo_on <= (tgt == TGT_LO) && (lo_on || (settled && !hi_on));
        end
    end
endmodule

// File: rtl/gate_seq.sv
module gate_seq
    import gsq_pkg::*;
#(
    parameter int SW = 8,
    parameter int DW = 8,
    parameter logic [SW-1:0] UV_LO = 8'd100,
    parameter logic [SW-1:0] UV_HI = 8'd110,
    parameter int REFRESH_CYC = 100
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dir,
    input  logic          hi_en,
    input  logic          dis,
    input  logic [SW-1:0] vsup,
    input  logic [DW-1:0] up_dly,
    input  logic [DW-1:0] lo_dly,
    output logic          a_hi,
    output logic          a_lo,
    output logic          b_hi,
    output logic          b_lo
);
    localparam int NLEG = 2;
    localparam int RW   = $clog2(REFRESH_CYC + 1);
    localparam logic [RW-1:0] REF_LAST = RW'(REFRESH_CYC - 1);

    seq_state_t    state;
    seq_state_t    state_nxt;
    logic [RW-1:0] ref_cnt;
    logic          uv;
    logic          kill;
    logic          ref_done;
    logic [NLEG-1:0] req_hi;
    logic [NLEG-1:0] req_lo;
    logic [NLEG-1:0] on_hi;
    logic [NLEG-1:0] on_lo;

    gsq_uvlo #(.SW(SW), .UV_LO(UV_LO), .UV_HI(UV_HI)) uvlo_i (
        .clk    (clk),
        .rst    (rst),
        .sample (vsup),
        .uv     (uv)
    );

    assign kill     = dis | uv;
    assign ref_done = (ref_cnt == REF_LAST);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_LOCK;
        else     state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst || (state != ST_REFRESH)) ref_cnt <= '0;
        else                              ref_cnt <= ref_cnt + 1'b1;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_LOCK:    if (!kill) state_nxt = ST_REFRESH;
            ST_REFRESH: begin
                if (kill)          state_nxt = ST_LOCK;
                else if (ref_done) state_nxt = ST_RUN;
            end
            ST_RUN:     if (kill) state_nxt = ST_LOCK;
            default:    state_nxt = ST_LOCK;
        endcase
    end

    // gate commands per state (index 0 = leg A, 1 = leg B)
    always_comb begin
        req_hi = '0;
        req_lo = '0;
        unique case (state)
            ST_LOCK: begin
                req_hi = '0;
                req_lo = '0;
            end
            ST_REFRESH: begin
                if (!kill) req_lo = '1;
            end
            ST_RUN: begin
                if (!kill) begin
                    req_hi[0] = hi_en & dir;
                    req_lo[0] = ~dir;
                    req_hi[1] = hi_en & ~dir;
                    req_lo[1] = dir;
                end
            end
            default: begin
                req_hi = '0;
                req_lo = '0;
            end
        endcase
    end

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        gsq_leg #(.DW(DW)) leg_i (
            .clk    (clk),
            .rst    (rst),
            .req_hi (req_hi[g]),
            .req_lo (req_lo[g]),
            .hi_dly (up_dly),
            .lo_dly (lo_dly),
            .hi_on  (on_hi[g]),
            .lo_on  (on_lo[g])
        );
    end

    assign a_hi = on_hi[0];
    assign a_lo = on_lo[0];
    assign b_hi = on_hi[1];
    assign b_lo = on_lo[1];
endmodule

// File: rtl/gate_seq_chk.sv
module gate_seq_chk #(
    parameter int SW = 8,
    parameter logic [SW-1:0] UV_LO = 8'd100
) (
    input logic          clk,
    input logic          rst,
    input logic          dis,
    input logic          hi_en,
    input logic [SW-1:0] vsup,
    input logic          a_hi,
    input logic          a_lo,
    input logic          b_hi,
    input logic          b_lo
);
    // R11
    leg_a_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(a_hi && a_lo));
    // R11
    leg_b_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(b_hi && b_lo));
    // R2
    dis_off_chk: assert property (@(posedge clk) disable iff (rst)
        dis |=> !(a_hi || a_lo || b_hi || b_lo));
    // R5
    hi_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !hi_en |=> !(a_hi || b_hi));
    // R3
    uv_off_chk: assert property (@(posedge clk) disable iff (rst)
        ((vsup < UV_LO) && $past(vsup < UV_LO)) |=> !(a_hi || a_lo || b_hi || b_lo));
    // R10
    a_hi_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(a_hi) |-> !$past(a_lo));
    // R10
    b_hi_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(b_hi) |-> !$past(b_lo));
    // R10
    a_lo_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(a_lo) |-> !$past(a_hi));
endmodule

bind gate_seq gate_seq_chk #(.SW(SW), .UV_LO(UV_LO)) chk_i (
    .clk   (clk),
    .rst   (rst),
    .dis   (dis),
    .hi_en (hi_en),
    .vsup  (vsup),
    .a_hi  (a_hi),
    .a_lo  (a_lo),
    .b_hi  (b_hi),
    .b_lo  (b_lo)
);

// File: tb/gate_seq_tb_top.sv
module gate_seq_tb_top;
    localparam logic [3:0] AH = 4'b1000;
    localparam logic [3:0] AL = 4'b0100;
    localparam logic [3:0] BH = 4'b0010;
    localparam logic [3:0] BL = 4'b0001;
    localparam int WATCHDOG = 20000;

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dir = 1'b1;
    logic       hi_en = 1'b1;
    logic       dis = 1'b0;
    logic [7:0] vsup = 8'd0;
    logic [7:0] up_dly = 8'd3;
    logic [7:0] lo_dly = 8'd5;
    logic       a_hi, a_lo, b_hi, b_lo;

    exp_item_t  sb_q[$];
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    gate_seq dut_i (
        .clk(clk), .rst(rst), .dir(dir), .hi_en(hi_en), .dis(dis),
        .vsup(vsup), .up_dly(up_dly), .lo_dly(lo_dly),
        .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input logic [3:0] e, input string tag);
        exp_item_t it;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // monitor: pops expected items and checks leg exclusivity every cycle
    always @(negedge clk) begin
        #1;
        while (sb_q.size() > 0) begin
            exp_item_t it;
            logic [3:0] obs;
            it = sb_q.pop_front();
            obs = {a_hi, a_lo, b_hi, b_lo};
            n_chk++;
            if (obs !== it.exp) begin
                n_fail++;
                $display("FAIL %s: got %b expected %b at %0t", it.tag, obs, it.exp, $time);
            end
        end
        if (!rst) begin
            n_chk++;
            if ((a_hi && a_lo) || (b_hi && b_lo)) begin
                n_fail++;
                $display("FAIL R11: got %b expected no leg with both on", {a_hi, a_lo, b_hi, b_lo});
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1 reset state
        step(4);
        expect_out(4'b0000, "R1 reset");
        rst = 1'b0;
        step(1);
        expect_out(4'b0000, "R1 after reset");
        // release from undervoltage; R6 refresh
        vsup = 8'd120;
        step(8);
        expect_out(4'b0000, "R8 lower delay not yet done");
        step(1);
        expect_out(AL | BL, "R6 refresh lowers on");
        step(93);
        expect_out(AL | BL, "R6 refresh last cycle");
        step(1);
        expect_out(BL, "R7 A lower off at once");
        step(3);
        expect_out(BL, "R8 upper delay running");
        step(1);
        expect_out(AH | BL, "R4 diagonal dir=1");
        // R4 commutate to other diagonal
        dir = 1'b0;
        step(1);
        expect_out(4'b0000, "R7 both legs off");
        step(3);
        expect_out(4'b0000, "R8 dead time");
        step(1);
        expect_out(BH, "R8 upper after up_dly");
        step(1);
        expect_out(BH, "R8 lower still waiting");
        step(1);
        expect_out(AL | BH, "R4 diagonal dir=0");
        // R5 upper gating
        hi_en = 1'b0;
        step(1);
        expect_out(AL, "R5 uppers off");
        step(10);
        expect_out(AL, "R5 lower follows dir=0");
        dir = 1'b1;
        step(1);
        expect_out(4'b0000, "R7 A lower off");
        step(5);
        expect_out(4'b0000, "R8 lower dead time");
        step(1);
        expect_out(BL, "R5 lower follows dir=1");
        // R9 restart of delay
        hi_en = 1'b1;
        step(1);
        hi_en = 1'b0;
        step(1);
        hi_en = 1'b1;
        step(4);
        expect_out(BL, "R9 count restarted");
        step(1);
        expect_out(AH | BL, "R9 on after full delay");
        // R10 zero delay
        up_dly = 8'd0;
        lo_dly = 8'd0;
        step(2);
        dir = 1'b0;
        step(1);
        expect_out(4'b0000, "R10 one cycle off");
        step(1);
        expect_out(AL | BH, "R10 on next cycle");
        // R2 disable
        dis = 1'b1;
        step(1);
        expect_out(4'b0000, "R2 disable off");
        dir = 1'b1;
        step(3);
        expect_out(4'b0000, "R2 disable holds");
        dir = 1'b0;
        dis = 1'b0;
        step(2);
        expect_out(4'b0000, "R6 refresh start");
        step(1);
        expect_out(AL | BL, "R6 refresh lowers");
        step(98);
        expect_out(AL | BL, "R6 refresh end");
        step(1);
        expect_out(AL, "R7 B lower off");
        step(1);
        expect_out(AL | BH, "R10 run after refresh");
        // R3 undervoltage hysteresis
        vsup = 8'd105;
        step(5);
        expect_out(AL | BH, "R3 mid band no lock");
        vsup = 8'd95;
        step(1);
        expect_out(AL | BH, "R3 flag latency");
        step(1);
        expect_out(4'b0000, "R3 locked");
        vsup = 8'd105;
        step(10);
        expect_out(4'b0000, "R3 mid band no release");
        vsup = 8'd111;
        step(3);
        expect_out(4'b0000, "R3 release pending");
        step(1);
        expect_out(AL | BL, "R6 refresh after uv");
        step(2);
        finish_run();
    end
endmodule